// File: doc/BRIEF.md
# Passive-Parallel Configuration Sequencer

This block drives the control pins of a target device through a complete full-image load in passive-parallel mode. A single start pulse runs the whole sequence. The block first checks the mode-select straps. It then waits for the external configuration pins to go quiet and takes over the nCONFIG and configuration lines. Next it selects the device, pulses nCONFIG while it tracks nSTATUS, and confirms that CONF_DONE is still low before it opens the data and clock enables for the image stream. After the last image word, the block waits for CONF_DONE and then for user mode. Finally it hands the pins back and checks the three status lines one last time.

Neighbouring logic supplies three inputs: the end-of-image strobe, a one-cycle pulse every millisecond that drives the timeouts, and the raw pin levels. Every pin level passes through a two-stage synchronizer first. Software or a neighbouring controller reads the result from a busy flag, a success flag and a two-bit error code. The data shifter and any parsing of the image lie outside this block.

Top module: `cfg_seq`

## Requirements
- R1: After reset, nconfig_o=1, nce_o=1, both override enables=0, both configuration enables=0, busy=0, done_ok=0 and err_code=0.
- R2: A start is refused when the synchronized mode-select value is greater than 1. A refused start sets err_code=1 and clears done_ok, and busy and all pin outputs stay unchanged. Values 0 and 1 are accepted.
- R3: Once a start is accepted, the block holds the pins released until the synchronized external nCONFIG and nSTATUS inputs both read 0. If TIMEOUT_MS millisecond ticks pass first, the run ends with err_code=2.
- R4: Once the pins are quiet, both overrides assert for exactly one cycle while nce_o stays 1. In the next cycle nce_o falls, and the block waits for quiet pins a second time, with the same timeout.
- R5: nconfig_o is held at 0 until synchronized nSTATUS reads 0. It then returns to 1 until nSTATUS reads 1. Each of these waits ends with err_code=2 after TIMEOUT_MS ticks.
- R6: After the pulse, CONF_DONE must read 0 and its output-enable status must read 1, or the run ends with err_code=3. Only after this check do cfg_ctl_en and cfg_data_en go to 1.
- R7: The enables stay on until image_end is seen. While the block then waits for CONF_DONE=1, nSTATUS=0 ends the run with err_code=3, and CD_LIMIT clock cycles without CONF_DONE end it with err_code=2.
- R8: After CONF_DONE, user mode must read 1 within TIMEOUT_MS ticks, or the run ends with err_code=2. When user mode arrives, the enables and overrides are cleared and nce_o returns to 1.
- R9: In the cycle after release, the block checks user mode, CONF_DONE and nSTATUS. If all three read 1, done_ok=1; otherwise err_code=3.
- R10: Any error returns the block to idle with its pins released. err_code and done_ok then hold their values until the next start.
- R11: A start that arrives while busy=1 has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a configuration run |
| image_end | input | 1 | One-cycle strobe after the last image word |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_ncfg | input | 1 | External nCONFIG pin level |
| pin_nst | input | 1 | nSTATUS pin level |
| pin_cd | input | 1 | CONF_DONE pin level |
| pin_cd_oe | input | 1 | CONF_DONE output-enable status |
| pin_um | input | 1 | User-mode indication |
| pin_msel | input | MSEL_W | Mode-select straps |
| nconfig_o | output | 1 | nCONFIG drive level |
| nce_o | output | 1 | Chip select, active low |
| ovr_cfg_o | output | 1 | Configuration-line override enable |
| ovr_ncfg_o | output | 1 | nCONFIG override enable |
| cfg_ctl_en | output | 1 | Configuration clock/control enable |
| cfg_data_en | output | 1 | Configuration data path enable |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Last run finished correctly |
| err_code | output | 2 | 0 none, 1 mode refused, 2 timeout, 3 pin-state violation |

## Verification
The assertions assume that the pin inputs change no more than once every few cycles, so that the synchronized values the sequencer acts on settle between decisions. They also assume that start and image_end are single-cycle pulses from the local clock domain. The stimulus never changes a pin level until at least two cycles after the output it responds to, and it waits for each phase to be reached before it drives the next pin. A reactive reference model checks every output on every clock. Directed runs add one fault each (a stuck pin, a missing level, or a dropped status) so that every error path is covered.

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int TIMEOUT_MS = 1000,
  parameter int CD_LIMIT   = 16777216,
  parameter int MSEL_W     = 3,
  parameter int MSEL_MAX   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              image_end,
  input  logic              ms_tick,
  input  logic              pin_ncfg,
  input  logic              pin_nst,
  input  logic              pin_cd,
  input  logic              pin_cd_oe,
  input  logic              pin_um,
  input  logic [MSEL_W-1:0] pin_msel,
  output logic              nconfig_o,
  output logic              nce_o,
  output logic              ovr_cfg_o,
  output logic              ovr_ncfg_o,
  output logic              cfg_ctl_en,
  output logic              cfg_data_en,
  output logic              busy,
  output logic              done_ok,
  output logic [1:0]        err_code
);

  localparam int SW   = MSEL_W + 5;
  localparam int LMAX = (CD_LIMIT > TIMEOUT_MS) ? CD_LIMIT : TIMEOUT_MS;
  localparam int TW   = $clog2(LMAX + 1);
  localparam logic [TW-1:0] TMO = TW'(TIMEOUT_MS);
  localparam logic [TW-1:0] CDL = TW'(CD_LIMIT);

  typedef enum logic [3:0] {
    S_IDLE, S_Q1, S_OVR, S_Q2, S_PLO, S_PHI,
    S_CDCHK, S_STREAM, S_WCD, S_WUM, S_FINAL
  } st_t;

  st_t st, nxt;
  logic [SW-1:0] s1, s2;
  logic [TW-1:0] tmr;
  logic [1:0]    fail, code_q;
  logic          inc, ok_q;

  logic ncfg_s, nst_s, cd_s, cdoe_s, um_s, msel_ok;
  logic [MSEL_W-1:0] msel_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {pin_msel, pin_um, pin_cd_oe, pin_cd, pin_nst, pin_ncfg};
      s2 <= s1;
    end

  assign {msel_s, um_s, cdoe_s, cd_s, nst_s, ncfg_s} = s2;
  assign msel_ok = (msel_s <= MSEL_W'(MSEL_MAX));

  always_comb begin
    nxt  = st;
    fail = 2'd0;
    inc  = 1'b0;
    case (st)
      S_IDLE:   if (start && msel_ok) nxt = S_Q1;
      S_Q1, S_Q2: begin
        inc = ms_tick;
        if (!ncfg_s && !nst_s) nxt = (st == S_Q1) ? S_OVR : S_PLO;
        else if (tmr == TMO)   fail = 2'd2;
      end
      S_OVR:    nxt = S_Q2;
      S_PLO: begin
        inc = ms_tick;
        if (!nst_s)            nxt = S_PHI;
        else if (tmr == TMO)   fail = 2'd2;
      end
      S_PHI: begin
        inc = ms_tick;
        if (nst_s)             nxt = S_CDCHK;
        else if (tmr == TMO)   fail = 2'd2;
      end
      S_CDCHK: begin
        if (!cd_s && cdoe_s)   nxt = S_STREAM;
        else                   fail = 2'd3;
      end
      S_STREAM: if (image_end) nxt = S_WCD;
      S_WCD: begin
        inc = 1'b1;
        if (cd_s)              nxt = S_WUM;
        else if (!nst_s)       fail = 2'd3;
        else if (tmr == CDL)   fail = 2'd2;
      end
      S_WUM: begin
        inc = ms_tick;
        if (um_s)              nxt = S_FINAL;
        else if (tmr == TMO)   fail = 2'd2;
      end
      S_FINAL: begin
        nxt = S_IDLE;
        if (!(um_s && cd_s && nst_s)) fail = 2'd3;
      end
      default:  nxt = S_IDLE;
    endcase
    if (fail != 2'd0) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      ok_q   <= 1'b0;
      code_q <= 2'd0;
    end else begin
      st  <= nxt;
      tmr <= (nxt != st) ? '0 : (inc ? tmr + 1'b1 : tmr);
      if (st == S_IDLE && start) begin
        ok_q   <= 1'b0;
        code_q <= msel_ok ? 2'd0 : 2'd1;
      end
      if (fail != 2'd0) code_q <= fail;
      if (st == S_FINAL && fail == 2'd0) ok_q <= 1'b1;
    end

  assign busy        = (st != S_IDLE);
  assign ovr_cfg_o   = st inside {S_OVR, S_Q2, S_PLO, S_PHI, S_CDCHK, S_STREAM, S_WCD, S_WUM};
  assign ovr_ncfg_o  = ovr_cfg_o;
  assign nce_o       = !(st inside {S_Q2, S_PLO, S_PHI, S_CDCHK, S_STREAM, S_WCD, S_WUM});
  assign nconfig_o   = (st != S_PLO);
  assign cfg_ctl_en  = st inside {S_STREAM, S_WCD, S_WUM};
  assign cfg_data_en = cfg_ctl_en;
  assign done_ok     = ok_q;
  assign err_code    = code_q;

  assert_msel_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !msel_ok |=> !busy && err_code == 2'd1);

  assert_pulse_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nconfig_o) |-> $past(!nst_s) || err_code == 2'd2);

  assert_cd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_data_en) |-> $past(!cd_s && cdoe_s));

  assert_nst_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WCD) && !cd_s && !nst_s |=> !busy && err_code == 2'd3);

  assert_final_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(um_s && cd_s && nst_s));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(err_code) && $stable(done_ok));

endmodule

// File: tb/sim_cfg_seq.sv
module sim_cfg_seq;
  localparam int TMO = 4;
  localparam int CDL = 30;

  logic clk = 0, rst_n = 0, start = 0, image_end = 0, ms_tick = 0;
  logic p_ncfg = 0, p_nst = 0, p_cd = 0, p_cdoe = 1, p_um = 0;
  logic [2:0] p_msel = 3'd1;
  logic nconfig_o, nce_o, ovr_cfg_o, ovr_ncfg_o, cfg_ctl_en, cfg_data_en, busy, done_ok;
  logic [1:0] err_code;

  cfg_seq #(.TIMEOUT_MS(TMO), .CD_LIMIT(CDL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .image_end(image_end), .ms_tick(ms_tick),
    .pin_ncfg(p_ncfg), .pin_nst(p_nst), .pin_cd(p_cd), .pin_cd_oe(p_cdoe), .pin_um(p_um),
    .pin_msel(p_msel), .nconfig_o(nconfig_o), .nce_o(nce_o), .ovr_cfg_o(ovr_cfg_o),
    .ovr_ncfg_o(ovr_ncfg_o), .cfg_ctl_en(cfg_ctl_en), .cfg_data_en(cfg_data_en),
    .busy(busy), .done_ok(done_ok), .err_code(err_code));

  always #4 clk = ~clk;

  int total = 0, bad = 0, tk = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    tk = (tk == 7) ? 0 : tk + 1;
    ms_tick = (tk == 0);
  end

  // reference model; phases: 0 idle,1 quiet1,2 override,3 quiet2,4 pulse low,
  // 5 pulse high,6 done check,7 stream,8 wait done,9 wait user,10 final
  int ph = 0, mt = 0;
  logic [1:0] mcode = 0;
  bit mok = 0;
  logic [7:0] q1 = 0, q2 = 0;

  always @(posedge clk) begin
    int np;
    int ec;
    logic [7:0] sv;
    if (!rst_n) begin
      ph = 0; mt = 0; mcode = 0; mok = 0; q1 = 0; q2 = 0;
    end else begin
      sv = q2; np = ph; ec = 0;
      case (ph)
        0: if (start) begin
             mok = 0;
             if (sv[7:5] > 3'd1) mcode = 1;
             else begin mcode = 0; np = 1; end
           end
        1, 3: if (!sv[0] && !sv[1]) np = (ph == 1) ? 2 : 4; else if (mt == TMO) ec = 2;
        2: np = 3;
        4: if (!sv[1]) np = 5; else if (mt == TMO) ec = 2;
        5: if (sv[1]) np = 6; else if (mt == TMO) ec = 2;
        6: if (!sv[2] && sv[3]) np = 7; else ec = 3;
        7: if (image_end) np = 8;
        8: if (sv[2]) np = 9; else if (!sv[1]) ec = 3; else if (mt == CDL) ec = 2;
        9: if (sv[4]) np = 10; else if (mt == TMO) ec = 2;
        10: begin np = 0; if (sv[4] && sv[2] && sv[1]) mok = 1; else ec = 3; end
        default: np = 0;
      endcase
      if (ec != 0) begin mcode = ec[1:0]; np = 0; end
      if (np != ph) mt = 0;
      else if (ph == 8 || (ms_tick && ph inside {1, 3, 4, 5, 9})) mt++;
      ph = np;
      q2 = q1;
      q1 = {p_msel, p_um, p_cdoe, p_cd, p_nst, p_ncfg};
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R11", int'(busy), int'(ph != 0), "busy");
    chk("R4", int'(ovr_cfg_o), int'(ph inside {[2:9]}), "cfg override");
    chk("R4", int'(ovr_ncfg_o), int'(ph inside {[2:9]}), "nconfig override");
    chk("R4", int'(nce_o), int'(!(ph inside {[3:9]})), "nce");
    chk("R5", int'(nconfig_o), int'(ph != 4), "nconfig");
    chk("R6", int'(cfg_data_en), int'(ph inside {[7:9]}), "data enable");
    chk("R8", int'(cfg_ctl_en), int'(ph inside {[7:9]}), "ctl enable");
    chk("R10", int'(err_code), int'(mcode), "err_code");
    chk("R9", int'(done_ok), int'(mok), "done_ok");
  end

  // f: 0 good, 1 quiet timeout, 3 bad done-oe, 4 nSTATUS drop, 5 no done,
  //    6 no user mode, 7 final check fail, 8 nSTATUS never rises
  task automatic run(int f, logic [2:0] ms);
    p_msel = ms; p_ncfg = (f == 1); p_nst = 0; p_cd = 0; p_cdoe = (f != 3); p_um = 0;
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (busy && !ovr_cfg_o) @(negedge clk);
    if (busy) begin
      chk("R4", int'(nce_o), 1, "nce while override first asserts");
      @(negedge clk);
      chk("R4", int'(nce_o), 0, "nce after override cycle");
    end
    while (busy && nconfig_o) @(negedge clk);
    if (busy) @(negedge clk);
    if (busy && f != 8) begin repeat (2) @(negedge clk); p_nst = 1; end
    while (busy && !cfg_data_en) @(negedge clk);
    if (busy) begin
      start = 1; @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      image_end = 1; @(negedge clk); image_end = 0;
    end
    if (busy) begin
      repeat (3) @(negedge clk);
      if (f == 4) p_nst = 0;
      else if (f != 5) p_cd = 1;
    end
    while (busy && !(f == 4 || f == 5) && !p_cd) @(negedge clk);
    if (busy && f != 6 && f != 4 && f != 5) begin
      repeat (12) @(negedge clk);
      p_um = 1;
      if (f == 7) p_nst = 0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(nconfig_o), 1, "reset nconfig");
    chk("R1", int'(nce_o), 1, "reset nce");
    chk("R1", int'(ovr_cfg_o | ovr_ncfg_o), 0, "reset overrides");
    chk("R1", int'(cfg_ctl_en | cfg_data_en), 0, "reset enables");
    chk("R1", int'(busy), 0, "reset busy");
    chk("R1", int'(done_ok), 0, "reset ok");
    chk("R1", int'(err_code), 0, "reset code");

    p_msel = 3'd3; repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0; @(negedge clk);
    chk("R2", int'(err_code), 1, "msel 3 refused");
    chk("R2", int'(busy), 0, "msel 3 stays idle");
    p_msel = 3'd2; repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0; @(negedge clk);
    chk("R2", int'(err_code), 1, "msel 2 refused");

    run(0, 3'd1);
    chk("R9", int'(done_ok), 1, "good run msel 1 ok");
    chk("R11", int'(err_code), 0, "mid-run start ignored");
    run(0, 3'd0);
    chk("R2", int'(done_ok), 1, "msel 0 accepted");

    run(1, 3'd1);
    chk("R3", int'(err_code), 2, "quiet-pin timeout");
    repeat (20) @(negedge clk);
    chk("R10", int'(err_code), 2, "code held while idle");
    chk("R10", int'(nce_o), 1, "pins released after error");

    run(8, 3'd1);
    chk("R5", int'(err_code), 2, "nSTATUS rise timeout");
    run(3, 3'd1);
    chk("R6", int'(err_code), 3, "done output-enable low");
    run(4, 3'd1);
    chk("R7", int'(err_code), 3, "nSTATUS low while waiting done");
    run(5, 3'd1);
    chk("R7", int'(err_code), 2, "done cycle timeout");
    run(6, 3'd1);
    chk("R8", int'(err_code), 2, "user mode timeout");
    run(7, 3'd1);
    chk("R9", int'(err_code), 3, "final check fails");
    chk("R9", int'(done_ok), 0, "no ok on final failure");
    run(0, 3'd1);
    chk("R10", int'(err_code), 0, "new start clears code");

    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end
endmodule